// File: doc/BRIEF.md
# Serial Transmit Channel with Line Break Control

This block is one transmit lane of a multi-lane asynchronous serial controller. The host writes a character into a single holding register. When the line is free, the character moves into a shift register, which sends it as a framed character: a low start bit, 5 to 8 data bits with the least significant bit first, an optional parity bit, and a high stop bit. Every bit lasts 16 pulses of an externally supplied bit-rate tick. All line changes take place on a bit boundary, which is every sixteenth tick counted from reset.

The host steers the lane with separate enable and disable strobes and with a 4-bit command code. The commands start and stop a line break, in which the data line is held low, and drive an active-low request-to-send output low or high. A break waits until every queued character has been sent. After a break ends, the line stays high for one full bit before the next character starts. Disabling the lane drops new writes at once, but characters already accepted are still sent. Two status outputs tell the host whether the holding register can take a character and whether the whole transmit path is empty.

Top module: `tx_break_channel`

## Requirements
- R1: After reset, `txd` is 1, `txRdy` is 0, `txEmt` is 0 and `rtsN` is 1.
- R2: Frame format. A frame is one start bit of 0, then the data bits least significant first, then an optional parity bit, then one stop bit of 1. The number of data bits is 5 + `cfgDataBits`. The parity bit is sent when `cfgParityEn` is 1. It is the XOR of the data bits, inverted when `cfgParityOdd` is 1. Each bit lasts 16 ticks, and every frame starts on a tick count since reset that is a multiple of 16.
- R3: One cycle after an enable strobe, with the line idle and nothing held, `txRdy` and `txEmt` are both 1.
- R4: A write made while `txRdy` is 1 is accepted, and one cycle later `txRdy` and `txEmt` are 0. `txRdy` returns to 1 at the bit boundary where that character's start bit begins.
- R5: A held character starts right after the stop bit of the character before it, with no gap. `txEmt` becomes 1 at the end of the last stop bit when nothing is held.
- R6: A write made while `txRdy` is 0 is ignored. This applies both when the lane is disabled and when the holding register is full.
- R7: One cycle after a disable strobe, `txRdy` and `txEmt` are 0. The character in progress and any held character are still sent in full, and `txEmt` stays 0 afterwards.
- R8: Command 0110 starts a break, in which `txd` is 0. On an idle lane the break begins at a bit boundary within two bit times. If characters are in progress or held, it begins exactly at the end of the last one's stop bit. The command is ignored while the lane is disabled.
- R9: Command 0111 ends a break. `txd` returns to 1 at a bit boundary within two bit times and stays 1 for exactly one bit time before a held character starts. If nothing is held, the line stays high.
- R10: Command 1000 drives `rtsN` to 0, and command 1001 drives it to 1.
- R11: Command codes other than 0110, 0111, 1000 and 1001 change neither the line, the status outputs nor `rtsN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitTick | input | 1 | One-cycle pulse, 16 per bit time |
| cfgDataBits | input | 2 | Data length select, length = 5 + value |
| cfgParityEn | input | 1 | Append a parity bit |
| cfgParityOdd | input | 1 | Select odd parity (1) or even parity (0) |
| cmdValid | input | 1 | Command code strobe |
| cmdCode | input | 4 | Command code |
| txEnableStb | input | 1 | Enable the transmitter |
| txDisableStb | input | 1 | Disable the transmitter |
| holdWrite | input | 1 | Write strobe for the holding register |
| holdData | input | 8 | Character to write |
| txd | output | 1 | Serial data line |
| txRdy | output | 1 | Holding register can accept a character |
| txEmt | output | 1 | Holding and shift registers both empty |
| rtsN | output | 1 | Active-low request-to-send |

## Verification
The assertions assume the following about the inputs: the enable and disable strobes are never raised in the same cycle, at most one command arrives per cycle, and the framing configuration changes only while the line is idle and nothing is held. The stimulus keeps to these rules. It changes the configuration only after the bench has seen `txEmt` return high, and it issues each strobe and each command as a single-cycle pulse from its own task. The bench computes each expected frame from the data value and the selected length and parity. It samples each bit at its middle, which it finds by counting ticks from the observed start edge. It judges break and mark timing from its own count of ticks since reset.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  localparam int CMD_W = 4;

  localparam logic [CMD_W-1:0] CMD_BRK_ON   = 4'b0110;
  localparam logic [CMD_W-1:0] CMD_BRK_OFF  = 4'b0111;
  localparam logic [CMD_W-1:0] CMD_RTS_LOW  = 4'b1000;
  localparam logic [CMD_W-1:0] CMD_RTS_HIGH = 4'b1001;

  typedef enum logic [1:0] {
    LINE_IDLE,
    LINE_SHIFT,
    LINE_BREAK,
    LINE_MARK
  } lineState_t;

  typedef struct packed {
    logic captureHold;
    logic loadFrame;
    logic advanceBit;
    logic shiftActive;
    logic breakActive;
  } txStrobes_t;

endpackage

// File: rtl/sertx_datapath.sv
module sertx_datapath
  import sertx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int DATA_MIN      = 5,
  parameter int DATA_MAX      = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                bitTick,
  input  logic [((DATA_MAX-DATA_MIN+1) > 1 ? $clog2(DATA_MAX-DATA_MIN+1) : 1)-1:0] cfgDataBits,
  input  logic                cfgParityEn,
  input  logic                cfgParityOdd,
  input  logic [DATA_MAX-1:0] holdData,
  input  txStrobes_t          strobes,
  output logic                boundary,
  output logic                lastBit,
  output logic                txd
);

  localparam int PHASE_W   = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam int FRAME_MAX = DATA_MAX + 3;
  localparam int CNT_W     = $clog2(FRAME_MAX + 1);

  logic [PHASE_W-1:0]   phase;
  logic [DATA_MAX-1:0]  holdReg;
  logic [FRAME_MAX-1:0] shiftReg;
  logic [FRAME_MAX-1:0] frameImg;
  logic [CNT_W-1:0]     bitsLeft;
  logic [CNT_W-1:0]     dataLen;
  logic [CNT_W-1:0]     frameLen;
  logic                 parAcc;

  // free-running bit phase, aligned to reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= '0;
    end else if (bitTick) begin
      if (phase == PHASE_W'(TICKS_PER_BIT - 1)) phase <= '0;
      else                                      phase <= phase + 1'b1;
    end
  end

  assign boundary = bitTick && (phase == PHASE_W'(TICKS_PER_BIT - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    holdReg <= '0;
    else if (strobes.captureHold) holdReg <= holdData;
  end

  // complete frame image built from the held character
  assign dataLen  = CNT_W'(DATA_MIN) + CNT_W'(cfgDataBits);
  assign frameLen = dataLen + CNT_W'(2) + CNT_W'(cfgParityEn);

  always_comb begin
    frameImg    = '1;
    frameImg[0] = 1'b0;
    parAcc      = cfgParityOdd;
    for (int i = 0; i < DATA_MAX; i++) begin
      if (CNT_W'(i) < dataLen) begin
        frameImg[i+1] = holdReg[i];
        parAcc        = parAcc ^ holdReg[i];
      end
    end
    if (cfgParityEn) frameImg[dataLen + CNT_W'(1)] = parAcc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '1;
      bitsLeft <= '0;
    end else if (strobes.loadFrame) begin
      shiftReg <= frameImg;
      bitsLeft <= frameLen;
    end else if (strobes.advanceBit) begin
      shiftReg <= {1'b1, shiftReg[FRAME_MAX-1:1]};
      bitsLeft <= bitsLeft - 1'b1;
    end
  end

  assign lastBit = (bitsLeft == CNT_W'(1));

  assign txd = strobes.breakActive ? 1'b0 :
               (strobes.shiftActive ? shiftReg[0] : 1'b1);

  // R2
  start_bit_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadFrame |=> !txd);

  // R2
  line_on_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    !boundary |=> $stable(txd));

  // R2
  bit_count_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitsLeft <= CNT_W'(FRAME_MAX));

endmodule

// File: rtl/sertx_control.sv
module sertx_control
  import sertx_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             boundary,
  input  logic             lastBit,
  input  logic             cmdValid,
  input  logic [CMD_W-1:0] cmdCode,
  input  logic             txEnableStb,
  input  logic             txDisableStb,
  input  logic             holdWrite,
  output txStrobes_t       strobes,
  output logic             txRdy,
  output logic             txEmt,
  output logic             rtsN
);

  lineState_t st, stNext;
  logic enabled, holdFull, emtReg, brkPend, stopPend, rtsReg;
  logic holdAccept, loadNow, advNow, frameDone, disableNow;
  logic cmdBrkOn, cmdBrkOff, cmdRtsLow, cmdRtsHigh;

  assign txRdy      = enabled && !holdFull;
  assign holdAccept = holdWrite && txRdy;
  assign disableNow = txDisableStb && !txEnableStb;
  assign cmdBrkOn   = cmdValid && (cmdCode == CMD_BRK_ON);
  assign cmdBrkOff  = cmdValid && (cmdCode == CMD_BRK_OFF);
  assign cmdRtsLow  = cmdValid && (cmdCode == CMD_RTS_LOW);
  assign cmdRtsHigh = cmdValid && (cmdCode == CMD_RTS_HIGH);

  // line sequencing, evaluated only on bit boundaries
  always_comb begin
    stNext    = st;
    loadNow   = 1'b0;
    advNow    = 1'b0;
    frameDone = 1'b0;
    if (boundary) begin
      unique case (st)
        LINE_IDLE: begin
          if (brkPend && enabled && !holdFull) begin
            stNext = LINE_BREAK;
          end else if (holdFull) begin
            loadNow = 1'b1;
            stNext  = LINE_SHIFT;
          end
        end
        LINE_SHIFT: begin
          if (!lastBit) begin
            advNow = 1'b1;
          end else begin
            frameDone = 1'b1;
            if (brkPend && enabled && !holdFull) stNext = LINE_BREAK;
            else if (holdFull)                   loadNow = 1'b1;
            else                                 stNext = LINE_IDLE;
          end
        end
        LINE_BREAK: begin
          if (stopPend) stNext = LINE_MARK;
        end
        LINE_MARK: begin
          if (holdFull) begin
            loadNow = 1'b1;
            stNext  = LINE_SHIFT;
          end else begin
            stNext = LINE_IDLE;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= LINE_IDLE;
    else       st <= stNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            enabled <= 1'b0;
    else if (txEnableStb) enabled <= 1'b1;
    else if (disableNow)  enabled <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           holdFull <= 1'b0;
    else if (holdAccept) holdFull <= 1'b1;
    else if (loadNow)    holdFull <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                            emtReg <= 1'b0;
    else if (disableNow)                                  emtReg <= 1'b0;
    else if (holdAccept)                                  emtReg <= 1'b0;
    else if (txEnableStb && st == LINE_IDLE && !holdFull) emtReg <= 1'b1;
    else if (frameDone && !holdFull && enabled)           emtReg <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                        brkPend <= 1'b0;
    else if (disableNow)                              brkPend <= 1'b0;
    else if (stNext == LINE_BREAK && st != LINE_BREAK) brkPend <= 1'b0;
    else if (cmdBrkOff)                               brkPend <= 1'b0;
    else if (cmdBrkOn && enabled && st != LINE_BREAK)  brkPend <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                            stopPend <= 1'b0;
    else if (stNext == LINE_MARK)                         stopPend <= 1'b0;
    else if (st == LINE_BREAK && (cmdBrkOff || disableNow)) stopPend <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           rtsReg <= 1'b1;
    else if (cmdRtsLow)  rtsReg <= 1'b0;
    else if (cmdRtsHigh) rtsReg <= 1'b1;
  end

  assign txEmt = emtReg;
  assign rtsN  = rtsReg;

  always_comb begin
    strobes.captureHold = holdAccept;
    strobes.loadFrame   = loadNow;
    strobes.advanceBit  = advNow;
    strobes.shiftActive = (st == LINE_SHIFT);
    strobes.breakActive = (st == LINE_BREAK);
  end

  // R7
  disable_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    disableNow |=> !txRdy && !txEmt);

  // R4
  write_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    holdAccept |=> !txRdy && !txEmt);

  // R8
  break_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(st == LINE_BREAK) |-> $past(boundary && !holdFull && enabled));

  // R9
  mark_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == LINE_MARK && !boundary) |=> st == LINE_MARK);

  // R10
  rts_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdRtsLow |=> !rtsN);

  // R10
  rts_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdRtsHigh |=> rtsN);

endmodule

// File: rtl/tx_break_channel.sv
module tx_break_channel
  import sertx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int DATA_MIN      = 5,
  parameter int DATA_MAX      = 8,
  localparam int SEL_W = ((DATA_MAX-DATA_MIN+1) > 1) ? $clog2(DATA_MAX-DATA_MIN+1) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                bitTick,
  input  logic [SEL_W-1:0]    cfgDataBits,
  input  logic                cfgParityEn,
  input  logic                cfgParityOdd,
  input  logic                cmdValid,
  input  logic [CMD_W-1:0]    cmdCode,
  input  logic                txEnableStb,
  input  logic                txDisableStb,
  input  logic                holdWrite,
  input  logic [DATA_MAX-1:0] holdData,
  output logic                txd,
  output logic                txRdy,
  output logic                txEmt,
  output logic                rtsN
);

  txStrobes_t strobes;
  logic       boundary;
  logic       lastBit;

  sertx_control u_control (
    .clk          (clk),
    .rstN         (rstN),
    .boundary     (boundary),
    .lastBit      (lastBit),
    .cmdValid     (cmdValid),
    .cmdCode      (cmdCode),
    .txEnableStb  (txEnableStb),
    .txDisableStb (txDisableStb),
    .holdWrite    (holdWrite),
    .strobes      (strobes),
    .txRdy        (txRdy),
    .txEmt        (txEmt),
    .rtsN         (rtsN)
  );

  sertx_datapath #(
    .TICKS_PER_BIT (TICKS_PER_BIT),
    .DATA_MIN      (DATA_MIN),
    .DATA_MAX      (DATA_MAX)
  ) u_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .bitTick      (bitTick),
    .cfgDataBits  (cfgDataBits),
    .cfgParityEn  (cfgParityEn),
    .cfgParityOdd (cfgParityOdd),
    .holdData     (holdData),
    .strobes      (strobes),
    .boundary     (boundary),
    .lastBit      (lastBit),
    .txd          (txd)
  );

endmodule

// File: tb/tx_break_channel_test.sv
module tx_break_channel_test;

  localparam int TPB = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitTick = 1'b0;
  logic [1:0] cfgDataBits = 2'd3;
  logic       cfgParityEn = 1'b0;
  logic       cfgParityOdd = 1'b0;
  logic       cmdValid = 1'b0;
  logic [3:0] cmdCode = 4'd0;
  logic       txEnableStb = 1'b0;
  logic       txDisableStb = 1'b0;
  logic       holdWrite = 1'b0;
  logic [7:0] holdData = 8'd0;
  logic       txd, txRdy, txEmt, rtsN;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  int tickDiv = 0;
  int edgeTicks = 0;

  tx_break_channel uut (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .cfgDataBits(cfgDataBits),
    .cfgParityEn(cfgParityEn), .cfgParityOdd(cfgParityOdd), .cmdValid(cmdValid),
    .cmdCode(cmdCode), .txEnableStb(txEnableStb), .txDisableStb(txDisableStb),
    .holdWrite(holdWrite), .holdData(holdData), .txd(txd), .txRdy(txRdy),
    .txEmt(txEmt), .rtsN(rtsN)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (!rstN) begin
      tickDiv <= 0;
      bitTick <= 1'b0;
    end else begin
      bitTick <= (tickDiv == 1);
      tickDiv <= (tickDiv == 1) ? 0 : tickDiv + 1;
    end
  end

  always @(posedge clk) if (rstN && bitTick) edgeTicks <= edgeTicks + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic writeHold(input int d);
    holdData = d[7:0];
    holdWrite = 1'b1;
    @(negedge clk);
    holdWrite = 1'b0;
  endtask

  task automatic sendCmd(input logic [3:0] c);
    cmdCode = c;
    cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic pulseEnable();
    txEnableStb = 1'b1;
    @(negedge clk);
    txEnableStb = 1'b0;
  endtask

  task automatic pulseDisable();
    txDisableStb = 1'b1;
    @(negedge clk);
    txDisableStb = 1'b0;
  endtask

  task automatic waitUntilTick(input int t);
    while (edgeTicks < t) @(negedge clk);
  endtask

  task automatic waitStart(output int s, output bit rdy);
    int lim;
    lim = edgeTicks + 4 * TPB;
    s = -1;
    rdy = 1'b0;
    while (edgeTicks < lim) begin
      if (txd == 1'b0) begin
        s = edgeTicks;
        rdy = txRdy;
        break;
      end
      @(negedge clk);
    end
    // R2: start edge found on a bit boundary
    check(s >= 0 && (s % TPB) == 0, "R2 start edge alignment", s, ((s + TPB - 1) / TPB) * TPB);
  endtask

  task automatic waitRise(output int r);
    int lim;
    lim = edgeTicks + 4 * TPB;
    r = -1;
    while (edgeTicks < lim) begin
      if (txd == 1'b1) begin
        r = edgeTicks;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic sampleFrame(input int s, input int d, input int nb, input bit pe,
                             input bit po, input string tag);
    int len, act, exp;
    bit par;
    len = 2 + nb + (pe ? 1 : 0);
    exp = 0;
    par = po;
    for (int i = 0; i < nb; i++) begin
      exp[1+i] = d[i];
      par = par ^ d[i];
    end
    if (pe) exp[nb+1] = par;
    exp[len-1] = 1'b1;
    act = 0;
    for (int k = 0; k < len; k++) begin
      waitUntilTick(s + TPB * k + TPB / 2);
      act[k] = txd;
    end
    check(act == exp, tag, act, exp);
  endtask

  task automatic lineQuiet(input int nBits, input string tag);
    int endT, lowSeen;
    endT = edgeTicks + TPB * nBits;
    lowSeen = 0;
    while (edgeTicks < endT) begin
      if (txd !== 1'b1) lowSeen++;
      @(negedge clk);
    end
    check(lowSeen == 0, tag, lowSeen, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int s, sB, r, c, f, d, mask, seed, len;
    bit rdy;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(txd == 1'b1, "R1 txd after reset", txd, 1);
    check(txRdy == 1'b0 && txEmt == 1'b0, "R1 status after reset", {txRdy, txEmt}, 0);
    check(rtsN == 1'b1, "R1 rtsN after reset", rtsN, 1);

    pulseEnable();
    // R3 enable on idle lane
    check(txRdy && txEmt, "R3 status after enable", {txRdy, txEmt}, 3);

    // R2 sweep of lengths, parity modes and data values
    for (int nb = 5; nb <= 8; nb++) begin
      for (int pm = 0; pm < 3; pm++) begin
        for (int v = 0; v < 2; v++) begin
          mask = (1 << nb) - 1;
          seed = nb * 37 + pm * 91 + 13;
          d = v ? (~seed & mask) : (seed & mask);
          cfgDataBits = 2'(nb - 5);
          cfgParityEn = (pm != 0);
          cfgParityOdd = (pm == 2);
          writeHold(d);
          // R4 write clears status
          check(!txRdy && !txEmt, "R4 status after write", {txRdy, txEmt}, 0);
          waitStart(s, rdy);
          // R4 ready returns as the start bit begins
          check(rdy == 1'b1, "R4 ready at start bit", rdy, 1);
          sampleFrame(s, d, nb, cfgParityEn, cfgParityOdd, "R2 frame contents");
          len = 2 + nb + (pm != 0 ? 1 : 0);
          waitUntilTick(s + TPB * len);
          // R5 empty after the last stop bit
          check(txEmt == 1'b1, "R5 empty after frame", txEmt, 1);
        end
      end
    end

    // R5 back-to-back, R6 write while full ignored
    cfgDataBits = 2'd3; cfgParityEn = 1'b0; cfgParityOdd = 1'b0;
    writeHold(8'hA5);
    waitStart(s, rdy);
    writeHold(8'h3C);
    check(txRdy == 1'b0, "R4 ready low while held", txRdy, 0);
    writeHold(8'h00);
    sampleFrame(s, 8'hA5, 8, 0, 0, "R5 first of pair");
    waitStart(sB, rdy);
    check(sB == s + 10 * TPB, "R5 no gap between frames", sB, s + 10 * TPB);
    sampleFrame(sB, 8'h3C, 8, 0, 0, "R6 held frame kept");
    waitUntilTick(sB + 10 * TPB);
    check(txEmt == 1'b1, "R5 empty after pair", txEmt, 1);
    lineQuiet(3, "R6 write while full dropped");

    // R8 break queued behind two characters
    writeHold(8'h81);
    waitStart(s, rdy);
    writeHold(8'h7E);
    sendCmd(4'b0110);
    sampleFrame(s, 8'h81, 8, 0, 0, "R8 first char before break");
    waitStart(sB, rdy);
    check(sB == s + 10 * TPB, "R8 held char before break", sB, s + 10 * TPB);
    sampleFrame(sB, 8'h7E, 8, 0, 0, "R8 second char before break");
    waitUntilTick(sB + 10 * TPB);
    check(txd == 1'b0, "R8 break at end of stop bit", txd, 0);
    waitUntilTick(sB + 10 * TPB + 40);
    check(txd == 1'b0, "R8 break held", txd, 0);

    // R9 stop break with a character held
    writeHold(8'h5A);
    check(txEmt == 1'b0, "R4 empty cleared during break", txEmt, 0);
    c = edgeTicks;
    sendCmd(4'b0111);
    waitRise(r);
    check(r >= 0 && (r % TPB) == 0 && (r - c) <= 2 * TPB, "R9 line high after stop", r - c, 2 * TPB);
    waitStart(s, rdy);
    check(s == r + TPB, "R9 one mark bit", s - r, TPB);
    sampleFrame(s, 8'h5A, 8, 0, 0, "R9 char after break");
    waitUntilTick(s + 10 * TPB);
    check(txEmt == 1'b1, "R5 empty after post-break char", txEmt, 1);

    // R8 break from idle, R9 stop with nothing held
    c = edgeTicks;
    sendCmd(4'b0110);
    waitStart(f, rdy);
    check(f - c <= 2 * TPB, "R8 idle break latency", f - c, 2 * TPB);
    waitUntilTick(f + 3 * TPB);
    check(txd == 1'b0, "R8 idle break held", txd, 0);
    sendCmd(4'b0111);
    waitRise(r);
    check(r >= 0 && (r % TPB) == 0, "R9 rise on boundary", r, ((r + TPB - 1) / TPB) * TPB);
    lineQuiet(2, "R9 line stays high");
    check(txEmt && txRdy, "R9 status after break", {txRdy, txEmt}, 3);

    // R10 and R11
    sendCmd(4'b1000);
    check(rtsN == 1'b0, "R10 rts low", rtsN, 0);
    sendCmd(4'b1111);
    sendCmd(4'b0101);
    sendCmd(4'b1011);
    sendCmd(4'b0000);
    check(rtsN == 1'b0 && txRdy && txEmt, "R11 unused codes", {rtsN, txRdy, txEmt}, 3);
    lineQuiet(2, "R11 line unchanged");
    sendCmd(4'b1001);
    check(rtsN == 1'b1, "R10 rts high", rtsN, 1);

    // R7 disable drains accepted characters
    writeHold(8'hC3);
    waitStart(s, rdy);
    writeHold(8'h1E);
    pulseDisable();
    check(!txRdy && !txEmt, "R7 status after disable", {txRdy, txEmt}, 0);
    sampleFrame(s, 8'hC3, 8, 0, 0, "R7 char in progress sent");
    waitStart(sB, rdy);
    check(sB == s + 10 * TPB, "R7 held char follows", sB, s + 10 * TPB);
    sampleFrame(sB, 8'h1E, 8, 0, 0, "R7 held char sent");
    waitUntilTick(sB + 10 * TPB);
    check(!txRdy && !txEmt, "R7 status after drain", {txRdy, txEmt}, 0);

    // R6 write while disabled, R8 break while disabled
    writeHold(8'h00);
    sendCmd(4'b0110);
    lineQuiet(4, "R8 break ignored when disabled");
    pulseEnable();
    check(txRdy && txEmt, "R3 status after re-enable", {txRdy, txEmt}, 3);
    lineQuiet(3, "R6 write while disabled dropped");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule